// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a slow time-base strobe, one pulse per cycle of a 32.768 kHz reference, into a programmable periodic event. A 7-bit control word holds a 3-bit divider-control field and a 4-bit rate code. A free-running 15-bit count advances on every time-base pulse while the divider-control field allows it to run. A tick happens on the pulse that brings this count to a multiple of the selected period. Because ticks follow the count's own boundaries, they keep the same phase when the rate is reprogrammed. They are not timed from the moment of the write.

Each tick sets a sticky periodic flag. When the periodic-interrupt enable input is high, the tick also sets the master interrupt flag, and the interrupt output follows that flag. A read-clear strobe from the host side clears both flags. The surrounding register file and the host bus are not part of this block.

Top module: `rtc_pit`

## Requirements
- R1: After reset the control readback `ctl_q` is 0x26 (divider-control 3'b010, rate code 6), both status flags are 0 and `irq` is low.
- R2: A cycle with `ctl_wr` high loads all seven bits of `ctl_wdata` into the control word, visible on `ctl_q` in the next cycle. Bits 6:4 are divider-control and bits 3:0 are the rate code.
- R3: With rate code 0 no tick occurs, whatever the count and the other inputs.
- R4: For rate codes 3 to 15 the period is 2^(code-1) time-base pulses.
- R5: Rate codes 1 and 2 are treated as codes 8 and 9, giving periods of 128 and 256 pulses.
- R6: A tick occurs exactly on a time-base pulse that takes the 15-bit count to a multiple of the current period. A change of rate code does not reset the count, so the first tick after the change falls on the next boundary of the new period.
- R7: The count runs only while divider-control is 0, 1 or 2. For any other value the count is held at zero and no tick occurs.
- R8: Every tick sets the periodic flag, `stat_q` bit 6. The flag stays set until cleared.
- R9: A tick sets the master interrupt flag, `stat_q` bit 7, only when `pie_en` is high in the tick's cycle. `irq` equals that flag.
- R10: A cycle with `stat_clr` high clears both flags. When a tick falls in the same cycle, the tick's flags are set anyway. All other bits of `stat_q` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 7 | Control word write data |
| ctl_q | output | 7 | Current control word |
| pie_en | input | 1 | Periodic interrupt enable |
| tb_pulse | input | 1 | Time-base pulse, one per 32.768 kHz cycle |
| stat_clr | input | 1 | Read-clear strobe for both flags |
| stat_q | output | 8 | Status byte: bit 7 interrupt flag, bit 6 periodic flag |
| irq | output | 1 | Interrupt output, active high |

## Verification
The assertions treat every cycle with `tb_pulse` high as one reference cycle. They expect the reset to be synchronous, so that no flag or count change is tied to a cycle that reset masked. The bench keeps pulses one clock wide with an idle clock between them. It changes the control word and `pie_en` only between pulses. It drives `stat_clr` together with a pulse only in the cycle meant to test the set-over-clear priority, so each tick lands in one defined cycle that the arithmetic model can place.

// File: rtl/rtc_pit_pkg.sv
package rtc_pit_pkg;
  localparam int CODE_W = 4;
  localparam int DV_W   = 3;
  localparam int CTL_W  = DV_W + CODE_W;
  localparam logic [CTL_W-1:0] CTL_RESET = 7'h26;

  // Low rate codes 1 and 2 are remapped onto the 8/9 slots.
  function automatic logic [CODE_W-1:0] eff_code(input logic [CODE_W-1:0] c);
    if (c == 4'd1 || c == 4'd2) return c + 4'd7;
    return c;
  endfunction

  // Position of the boundary bit for a nonzero effective code: period = 2^(e-1).
  function automatic logic [CODE_W-1:0] period_log2(input logic [CODE_W-1:0] c);
    return eff_code(c) - 4'd1;
  endfunction

  function automatic logic dv_runs(input logic [DV_W-1:0] dv);
    return dv <= 3'd2;
  endfunction
endpackage

// File: rtl/rtc_pit_prescaler.sv
module rtc_pit_prescaler #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic             tb_pulse,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next
);
  assign cnt_next = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!running) cnt_q <= '0;
    else if (tb_pulse) cnt_q <= cnt_next;
  end

  // R7: a stopped divider holds the count at zero
  a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> cnt_q == '0);
  // R6: the count only moves on a time-base pulse
  a_r6_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
    running && !tb_pulse |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_pit_rate.sv
module rtc_pit_rate
  import rtc_pit_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              running,
  input  logic              tb_pulse,
  input  logic [CNT_W-1:0]  cnt_next,
  output logic              tick
);
  localparam int NSLOT = 2 ** CODE_W;

  logic [NSLOT-1:0]  boundary;
  logic [CODE_W-1:0] sel;
  logic              code_on;

  assign boundary[0] = 1'b1;
  generate
    for (genvar k = 1; k < NSLOT; k++) begin : g_bnd
      if (k <= CNT_W) begin : g_real
        assign boundary[k] = ~|cnt_next[k-1:0];
      end else begin : g_none
        assign boundary[k] = 1'b0;
      end
    end
  endgenerate

  assign sel     = period_log2(code);
  assign code_on = (code != '0);
  assign tick    = tb_pulse & running & code_on & boundary[sel];

  // R3 R7: a tick needs a pulse, a running divider and a nonzero code
  a_r3_tick_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> tb_pulse && running && (code != '0));
endmodule

// File: rtl/rtc_pit_flags.sv
module rtc_pit_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pie_en,
  input  logic stat_clr,
  output logic pf_q,
  output logic irqf_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_q   <= 1'b0;
      irqf_q <= 1'b0;
    end else begin
      pf_q   <= (pf_q & ~stat_clr) | tick;
      irqf_q <= (irqf_q & ~stat_clr) | (tick & pie_en);
    end
  end

  // R8: every tick leaves the periodic flag set
  a_r8_tick_sets_pf: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pf_q);
  // R9: the interrupt flag only rises from an enabled tick
  a_r9_irqf_needs_pie: assert property (@(posedge clk) disable iff (!rst_n)
    !irqf_q ##1 irqf_q |-> $past(pie_en) && $past(tick));
  // R10: a clear without a tick empties both flags
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr && !tick |=> !pf_q && !irqf_q);
  // R8 R10: the periodic flag only rises from a tick
  a_r8_pf_source: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_q ##1 pf_q |-> $past(tick));
endmodule

// File: rtl/rtc_pit.sv
module rtc_pit
  import rtc_pit_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_q,
  input  logic             pie_en,
  input  logic             tb_pulse,
  input  logic             stat_clr,
  output logic [7:0]       stat_q,
  output logic             irq
);
  localparam int MIN_CNT_W = 2 ** CODE_W - 1;

  logic [CTL_W-1:0]  ctl_r;
  logic [CODE_W-1:0] code;
  logic [DV_W-1:0]   dv;
  logic              running;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_next;
  logic              tick;
  logic              pf_q;
  logic              irqf_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_r <= CTL_RESET;
    else if (ctl_wr) ctl_r <= ctl_wdata;
  end

  assign code    = ctl_r[CODE_W-1:0];
  assign dv      = ctl_r[CTL_W-1:CODE_W];
  assign running = dv_runs(dv);

  rtc_pit_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .running  (running),
    .tb_pulse (tb_pulse),
    .cnt_q    (cnt_q),
    .cnt_next (cnt_next)
  );

  rtc_pit_rate #(.CNT_W(CNT_W)) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .code     (code),
    .running  (running),
    .tb_pulse (tb_pulse),
    .cnt_next (cnt_next),
    .tick     (tick)
  );

  rtc_pit_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .pie_en   (pie_en),
    .stat_clr (stat_clr),
    .pf_q     (pf_q),
    .irqf_q   (irqf_q)
  );

  assign ctl_q  = ctl_r;
  assign stat_q = {irqf_q, pf_q, 6'b0};
  assign irq    = irqf_q;

  initial begin
    a_cnt_width: assert (CNT_W >= MIN_CNT_W);
  end

  // R2: a write lands in the control word one cycle later
  a_r2_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> ctl_q == $past(ctl_wdata));
  // R6: with the divider running, a tick moves the count to a new value
  a_r6_tick_advances: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !ctl_wr |=> !$stable(cnt_q));
endmodule

// File: tb/rtc_pit_test.sv
module rtc_pit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [6:0] ctl_wdata = '0;
  logic [6:0] ctl_q;
  logic       pie_en = 1'b0;
  logic       tb_pulse = 1'b0;
  logic       stat_clr = 1'b0;
  logic [7:0] stat_q;
  logic       irq;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  int       m_cnt = 0;
  bit [6:0] m_ctl = 7'h26;
  bit       m_pf = 0, m_irqf = 0;
  int       ticks_seen = 0;

  always #2.5 clk = ~clk;

  rtc_pit uut (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000 && !done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got cycle %0d expected < 190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input int act, input int exp, input string req);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h (count %0d ctl 0x%0h)", req, act, exp, m_cnt, m_ctl);
    end
  endtask

  function automatic bit m_run();
    return m_ctl[6:4] <= 3'd2;
  endfunction

  function automatic bit m_tick();
    int c, e, p;
    c = m_ctl[3:0];
    if (!m_run() || c == 0) return 0;
    e = (c == 1 || c == 2) ? c + 7 : c;
    p = 1 << (e - 1);
    return ((m_cnt + 1) % p) == 0;
  endfunction

  task automatic check_status(input string req);
    chk(stat_q, {m_irqf, m_pf, 6'b0}, req);
    chk(irq, m_irqf, req);
  endtask

  task automatic write_ctl(input bit [6:0] v);
    ctl_wr = 1; ctl_wdata = v;
    @(posedge clk); @(negedge clk);
    ctl_wr = 0;
    m_ctl = v;
    if (!m_run()) m_cnt = 0;
    chk(ctl_q, v, "R2");
  endtask

  task automatic clear_flags();
    stat_clr = 1;
    @(posedge clk); @(negedge clk);
    stat_clr = 0;
    m_pf = 0; m_irqf = 0;
    check_status("R10");
  endtask

  task automatic pulse(input bit clr, input string req);
    bit t;
    t = m_tick();
    tb_pulse = 1; stat_clr = clr;
    @(posedge clk); @(negedge clk);
    tb_pulse = 0; stat_clr = 0;
    m_cnt = m_run() ? (m_cnt + 1) % 32768 : 0;
    if (clr) begin m_pf = 0; m_irqf = 0; end
    if (t) begin
      m_pf = 1;
      if (pie_en) m_irqf = 1;
      ticks_seen++;
    end
    check_status(req);
    @(negedge clk);
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      pulse(0, req);
      if (m_pf) clear_flags();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ctl_q, 7'h26, "R1");
    check_status("R1");

    // R2: all seven bits load
    write_ctl(7'h5A);
    write_ctl(7'h26);

    // R3 R4 R5 R6 R8 R9: every rate code, interrupts enabled
    pie_en = 1;
    for (int c = 0; c < 16; c++) begin
      write_ctl({3'b010, 4'(c)});
      ticks_seen = 0;
      run(600, c == 0 ? "R3" : (c <= 2 ? "R5" : "R4"));
      if (c == 0) chk(ticks_seen, 0, "R3");
      if (c == 3) chk(ticks_seen, 150, "R4");
    end

    // R6: rate change mid-period keeps the count and lands on the new boundary
    write_ctl(7'h26);
    run(5, "R6");
    write_ctl(7'h23);
    run(20, "R6");

    // R9: ticks with interrupts disabled set only the periodic flag
    pie_en = 0;
    write_ctl(7'h23);
    for (int i = 0; i < 40; i++) pulse(0, "R9");
    chk(stat_q[7], 0, "R9");
    chk(stat_q[6], 1, "R8");
    clear_flags();
    pie_en = 1;

    // R7: divider-control sweep
    for (int d = 0; d < 8; d++) begin
      write_ctl({3'(d), 4'd3});
      ticks_seen = 0;
      run(40, "R7");
      chk(ticks_seen, d <= 2 ? 10 : 0, "R7");
    end

    // R10: tick and clear in the same cycle, tick wins
    write_ctl(7'h23);
    while (!m_tick()) pulse(0, "R10");
    pulse(0, "R10");
    chk(stat_q[6], 1, "R10");
    while (!m_tick()) pulse(0, "R10");
    pulse(1, "R10");
    chk(stat_q, 8'hC0, "R10");
    clear_flags();

    // R4: longest period
    write_ctl(7'h2F);
    ticks_seen = 0;
    run(17000, "R4");
    chk(ticks_seen >= 1, 1, "R4");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule